// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one down-counting channel of a multi-channel interval timer. A host-interface block, which is not part of this design, programs the channel in two steps. It first writes an operating mode, then loads a 16-bit initial count. From then on the channel decrements once per cycle in which the counter clock enable is high. It drives an OUT waveform chosen by the mode: terminal-count interrupt, retriggerable one-shot, rate generator, square wave, software strobe or hardware strobe.

The live count is always visible on `count_o`, so the host side can latch it. A gate input acts in one of two ways, depending on the mode. It either enables and suspends counting, or its rising edge restarts the count from the stored initial value. Counting is binary only. A loaded value of zero stands for 65536.

Top module: `ictr_channel`

## Requirements
- R1: A loaded count of 0 acts as 65536 in every mode: in mode 0 OUT rises on exactly the 65536th tick, and the first tick moves the count from 0 to 0xFFFF.
- R2: Mode 0 (`mode_i`=0): after a load OUT is 0. OUT becomes 1 on the tick that takes the count from 1 to 0, and stays 1 until the next mode write or load.
- R3: Mode 1 (`mode_i`=1): after a load OUT is 0. OUT becomes 1 on the tick that takes the count from 1 to 0. Counting does not depend on the gate level.
- R4: Mode 2 (`mode_i`=2 or 6): OUT is 1 after a load. On the tick where the count is 1, the count reloads the initial value and OUT is 0 until the next tick, which sets it back to 1.
- R5: Mode 3 (`mode_i`=3 or 7): the count steps down by 2 per tick and is always even. OUT is 1 for (N+1)/2 ticks and 0 for N/2 ticks of each N-tick period, with integer division.
- R6: Modes 4 and 5 (`mode_i`=4, 5): OUT is 1 after a load. OUT is 0 for exactly one tick, the one where the count goes from 1 to 0, and does so only once per load or restart.
- R7: In modes 0, 1, 4 and 5 the count keeps decrementing past zero and wraps modulo 65536 without reloading.
- R8: While armed, a rising edge on `gate_i` (0 in the previous clock, 1 now) restarts the count from the initial value in modes 1, 2, 3 and 5. In modes 0 and 4 it leaves the count unchanged.
- R9: In modes 0, 2, 3 and 4 ticks are ignored while `gate_i` is 0. In modes 1 and 5 the gate level does not stop counting.
- R10: A mode write sets OUT in the next cycle to its idle level: 0 for mode 0, 1 for all others. The count then stays frozen until a count is loaded.
- R11: After reset OUT is 0, the count is 0 and the channel is unarmed in mode 0.
- R12: When `tick_en_i` is 0 and there is neither a load nor a restarting gate edge, the count does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en_i | input | 1 | Counter clock enable, one tick per high cycle |
| gate_i | input | 1 | Gate input, level or rising-edge depending on mode |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_i | input | 3 | Mode code; 6 and 7 alias 2 and 3 |
| cnt_ld_i | input | 1 | Initial count load strobe |
| cnt_i | input | 16 | Initial count (0 means 65536) |
| out_o | output | 1 | Channel output waveform |
| count_o | output | 16 | Live counter value |

## Verification
The hardest state to reach from the ports is the one-shot strobe after a full wrap. Modes 4 and 5 must not pulse again when the count passes 1 for the second time. Reaching that point takes 65536 further ticks after the first pulse. The bench drives that long tick run directly, and it also drives the full 65536-tick run for a zero load in mode 0. Gate restarts are reached by holding counting steady, then dropping the gate for a single clock and raising it again, so that the edge appears without any interleaved tick.

// File: rtl/ictr_pkg.sv
package ictr_pkg;

    typedef enum logic [2:0] {
        M_TC_INT    = 3'd0,
        M_ONESHOT   = 3'd1,
        M_RATE      = 3'd2,
        M_SQUARE    = 3'd3,
        M_SW_STROBE = 3'd4,
        M_HW_STROBE = 3'd5
    } ictr_mode_e;

    // Codes 6 and 7 fold onto the rate and square modes.
    function automatic ictr_mode_e norm_mode(input logic [2:0] raw);
        if (raw[2] && raw[1])
            return ictr_mode_e'({1'b0, raw[1:0]});
        return ictr_mode_e'(raw);
    endfunction

    // Level OUT takes after a mode write, before any count is loaded.
    function automatic logic idle_level(input ictr_mode_e m);
        return (m != M_TC_INT);
    endfunction

    // Level OUT takes when counting (re)starts.
    function automatic logic start_level(input ictr_mode_e m);
        return !(m == M_TC_INT || m == M_ONESHOT);
    endfunction

    // Modes where a rising gate edge restarts the count.
    function automatic logic gate_retrig(input ictr_mode_e m);
        return (m == M_ONESHOT) || (m == M_RATE) ||
               (m == M_SQUARE) || (m == M_HW_STROBE);
    endfunction

    // Modes where a low gate suspends counting.
    function automatic logic gate_level_en(input ictr_mode_e m);
        return (m == M_TC_INT) || (m == M_RATE) ||
               (m == M_SQUARE) || (m == M_SW_STROBE);
    endfunction

endpackage

// File: rtl/ictr_gate_edge.sv
module ictr_gate_edge (
    input  logic clk,
    input  logic rst,
    input  logic gate_i,
    output logic gate_q_o,
    output logic rise_o
);
    logic gate_q;

    always_ff @(posedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= gate_i;
    end

    assign gate_q_o = gate_q;
    assign rise_o   = gate_i & ~gate_q;
endmodule

// File: rtl/ictr_ctl.sv
module ictr_ctl
    import ictr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode_wr_i,
    input  logic [2:0]   mode_i,
    input  logic         cnt_ld_i,
    input  logic [W-1:0] cnt_i,
    output ictr_mode_e   mode_o,
    output ictr_mode_e   mode_wr_val_o,
    output logic         armed_o,
    output logic [W:0]   init_o,
    output logic [W:0]   ld_ext_o
);
    localparam logic [W:0] FULL = {1'b1, {W{1'b0}}};

    ictr_mode_e mode_q;
    logic       armed_q;
    logic [W:0] init_q;

    assign mode_wr_val_o = norm_mode(mode_i);
    assign ld_ext_o      = (cnt_i == '0) ? FULL : {1'b0, cnt_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= M_TC_INT;
            armed_q <= 1'b0;
            init_q  <= FULL;
        end else begin
            if (mode_wr_i) begin
                mode_q  <= mode_wr_val_o;
                armed_q <= 1'b0;
            end else if (cnt_ld_i) begin
                armed_q <= 1'b1;
            end
            if (cnt_ld_i)
                init_q <= ld_ext_o;
        end
    end

    assign mode_o  = mode_q;
    assign armed_o = armed_q;
    assign init_o  = init_q;
endmodule

// File: rtl/ictr_core.sv
module ictr_core
    import ictr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  ictr_mode_e   mode_i,
    input  ictr_mode_e   mode_wr_val_i,
    input  logic         armed_i,
    input  logic [W:0]   init_i,
    input  logic [W:0]   ld_ext_i,
    input  logic         mode_wr_i,
    input  logic         cnt_ld_i,
    input  logic         tick_en_i,
    input  logic         gate_i,
    input  logic         gate_rise_i,
    output logic [W-1:0] count_o,
    output logic         out_o
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] TWO  = W'(2);
    localparam logic [W:0]   EVEN = ~(W + 1)'(1);

    // Square-wave phase lengths, in count units (two per tick).
    function automatic logic [W-1:0] sq_high(input logic [W:0] n);
        logic [W:0] r;
        r = (n + (W + 1)'(1)) & EVEN;
        return r[W-1:0];
    endfunction

    function automatic logic [W-1:0] sq_low(input logic [W:0] n);
        logic [W:0] r;
        r = n & EVEN;
        return r[W-1:0];
    endfunction

    function automatic logic [W-1:0] start_cnt(input ictr_mode_e m, input logic [W:0] n);
        if (m == M_SQUARE) return sq_high(n);
        return n[W-1:0];
    endfunction

    logic [W-1:0] cnt_q, cnt_n;
    logic         out_q, out_n;
    logic         done_q, done_n;
    logic         advance;

    assign advance = tick_en_i && (gate_i || !gate_level_en(mode_i));

    always_comb begin
        cnt_n  = cnt_q;
        out_n  = out_q;
        done_n = done_q;
        if (mode_wr_i) begin
            out_n = idle_level(mode_wr_val_i);
        end else if (cnt_ld_i) begin
            cnt_n  = start_cnt(mode_i, ld_ext_i);
            out_n  = start_level(mode_i);
            done_n = 1'b0;
        end else if (armed_i) begin
            if (gate_rise_i && gate_retrig(mode_i)) begin
                cnt_n  = start_cnt(mode_i, init_i);
                out_n  = start_level(mode_i);
                done_n = 1'b0;
            end else if (advance) begin
                unique case (mode_i)
                    M_TC_INT, M_ONESHOT: begin
                        cnt_n = cnt_q - ONE;
                        if (cnt_q == ONE) out_n = 1'b1;
                    end
                    M_RATE: begin
                        if (cnt_q == ONE) begin
                            cnt_n = init_i[W-1:0];
                            out_n = 1'b0;
                        end else begin
                            cnt_n = cnt_q - ONE;
                            out_n = 1'b1;
                        end
                    end
                    M_SQUARE: begin
                        if (cnt_q == TWO) begin
                            out_n = !out_q;
                            cnt_n = out_q ? sq_low(init_i) : sq_high(init_i);
                        end else begin
                            cnt_n = cnt_q - TWO;
                        end
                    end
                    default: begin
                        cnt_n = cnt_q - ONE;
                        if (cnt_q == ONE && !done_q) begin
                            out_n  = 1'b0;
                            done_n = 1'b1;
                        end else begin
                            out_n = 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            out_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_n;
            out_q  <= out_n;
            done_q <= done_n;
        end
    end

    assign count_o = cnt_q;
    assign out_o   = out_q;
endmodule

// File: rtl/ictr_channel.sv
module ictr_channel
    import ictr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en_i,
    input  logic         gate_i,
    input  logic         mode_wr_i,
    input  logic [2:0]   mode_i,
    input  logic         cnt_ld_i,
    input  logic [W-1:0] cnt_i,
    output logic         out_o,
    output logic [W-1:0] count_o
);
    ictr_mode_e mode_q;
    ictr_mode_e mode_wr_val;
    logic       armed;
    logic [W:0] init_val;
    logic [W:0] ld_ext;
    logic       gate_q;
    logic       gate_rise;

    ictr_gate_edge u_gate (
        .clk      (clk),
        .rst      (rst),
        .gate_i   (gate_i),
        .gate_q_o (gate_q),
        .rise_o   (gate_rise)
    );

    ictr_ctl #(.W(W)) u_ctl (
        .clk           (clk),
        .rst           (rst),
        .mode_wr_i     (mode_wr_i),
        .mode_i        (mode_i),
        .cnt_ld_i      (cnt_ld_i),
        .cnt_i         (cnt_i),
        .mode_o        (mode_q),
        .mode_wr_val_o (mode_wr_val),
        .armed_o       (armed),
        .init_o        (init_val),
        .ld_ext_o      (ld_ext)
    );

    ictr_core #(.W(W)) u_core (
        .clk           (clk),
        .rst           (rst),
        .mode_i        (mode_q),
        .mode_wr_val_i (mode_wr_val),
        .armed_i       (armed),
        .init_i        (init_val),
        .ld_ext_i      (ld_ext),
        .mode_wr_i     (mode_wr_i),
        .cnt_ld_i      (cnt_ld_i),
        .tick_en_i     (tick_en_i),
        .gate_i        (gate_i),
        .gate_rise_i   (gate_rise),
        .count_o       (count_o),
        .out_o         (out_o)
    );
endmodule

// File: rtl/ictr_channel_chk.sv
module ictr_channel_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         tick_en_i,
    input logic         gate_i,
    input logic         mode_wr_i,
    input logic [2:0]   mode_i,
    input logic         cnt_ld_i,
    input logic         out_o,
    input logic [W-1:0] count_o,
    input logic [2:0]   mode_q,
    input logic         armed,
    input logic         gate_q
);
    AST_MODE_IDLE: assert property (@(posedge clk) disable iff (rst)
        mode_wr_i |=> (out_o == ($past(mode_i) != 3'd0)));  // R10

    AST_UNARMED_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!armed && !cnt_ld_i) |=> $stable(count_o));  // R10

    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        (cnt_ld_i && !mode_wr_i && (mode_q == 3'd0 || mode_q == 3'd1)) |=> !out_o);  // R3

    AST_TC_STICKY: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 3'd0 && armed && out_o && !mode_wr_i && !cnt_ld_i) |=> out_o);  // R2

    AST_SQ_EVEN: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 3'd3 && armed) |-> !count_o[0]);  // R5

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick_en_i && !cnt_ld_i && !(gate_i && !gate_q)) |=> $stable(count_o));  // R12
endmodule

bind ictr_channel ictr_channel_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en_i (tick_en_i),
    .gate_i    (gate_i),
    .mode_wr_i (mode_wr_i),
    .mode_i    (mode_i),
    .cnt_ld_i  (cnt_ld_i),
    .out_o     (out_o),
    .count_o   (count_o),
    .mode_q    (mode_q),
    .armed     (armed),
    .gate_q    (gate_q)
);

// File: tb/ictr_channel_bench.sv
module ictr_channel_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int WATCHDOG = 195000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick_en_i = 1'b0;
    logic         gate_i = 1'b0;
    logic         mode_wr_i = 1'b0;
    logic [2:0]   mode_i = 3'd0;
    logic         cnt_ld_i = 1'b0;
    logic [W-1:0] cnt_i = '0;
    logic         out_o;
    logic [W-1:0] count_o;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ictr_channel #(.W(W)) u_ictr_channel (
        .clk(clk), .rst(rst), .tick_en_i(tick_en_i), .gate_i(gate_i),
        .mode_wr_i(mode_wr_i), .mode_i(mode_i), .cnt_ld_i(cnt_ld_i),
        .cnt_i(cnt_i), .out_o(out_o), .count_o(count_o)
    );

    typedef struct packed {
        logic [2:0]  mode;
        logic [15:0] cnt;
        logic        gate;
        logic [7:0]  ticks;
        logic        exp_out;
        logic [15:0] exp_cnt;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 16'd5, 1'b1, 8'd4, 1'b0, 16'd1,      8'd2},
        '{3'd0, 16'd5, 1'b1, 8'd5, 1'b1, 16'd0,      8'd2},
        '{3'd0, 16'd5, 1'b1, 8'd7, 1'b1, 16'hFFFE,   8'd7},
        '{3'd0, 16'd5, 1'b0, 8'd7, 1'b0, 16'd5,      8'd9},
        '{3'd1, 16'd3, 1'b0, 8'd2, 1'b0, 16'd1,      8'd3},
        '{3'd1, 16'd3, 1'b0, 8'd3, 1'b1, 16'd0,      8'd3},
        '{3'd1, 16'd3, 1'b0, 8'd5, 1'b1, 16'hFFFE,   8'd7},
        '{3'd2, 16'd4, 1'b1, 8'd3, 1'b1, 16'd1,      8'd4},
        '{3'd2, 16'd4, 1'b1, 8'd4, 1'b0, 16'd4,      8'd4},
        '{3'd2, 16'd4, 1'b1, 8'd5, 1'b1, 16'd3,      8'd4},
        '{3'd6, 16'd4, 1'b1, 8'd4, 1'b0, 16'd4,      8'd4},
        '{3'd3, 16'd6, 1'b1, 8'd2, 1'b1, 16'd2,      8'd5},
        '{3'd3, 16'd6, 1'b1, 8'd3, 1'b0, 16'd6,      8'd5},
        '{3'd3, 16'd6, 1'b1, 8'd6, 1'b1, 16'd6,      8'd5},
        '{3'd7, 16'd5, 1'b1, 8'd3, 1'b0, 16'd4,      8'd5},
        '{3'd3, 16'd5, 1'b1, 8'd5, 1'b1, 16'd6,      8'd5},
        '{3'd4, 16'd3, 1'b1, 8'd3, 1'b0, 16'd0,      8'd6},
        '{3'd4, 16'd3, 1'b1, 8'd4, 1'b1, 16'hFFFF,   8'd6},
        '{3'd4, 16'd3, 1'b0, 8'd3, 1'b1, 16'd3,      8'd9},
        '{3'd5, 16'd3, 1'b0, 8'd3, 1'b0, 16'd0,      8'd6}
    };

    task automatic check(input logic cond, input string req,
                         input logic [W:0] got, input logic [W:0] exp);
        n_run++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic check_out(input string req, input logic exp);
        check(out_o === exp, {req, " out"}, {16'd0, out_o}, {16'd0, exp});
    endtask

    task automatic check_cnt(input string req, input logic [W-1:0] exp);
        check(count_o === exp, {req, " count"}, {1'b0, count_o}, {1'b0, exp});
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_mode(input logic [2:0] m);
        mode_wr_i = 1'b1; mode_i = m;
        cyc(1);
        mode_wr_i = 1'b0;
    endtask

    task automatic load(input logic [W-1:0] c);
        cnt_ld_i = 1'b1; cnt_i = c;
        cyc(1);
        cnt_ld_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en_i = 1'b1;
        cyc(n);
        tick_en_i = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R11 reset state
        check_out("R11", 1'b0);
        check_cnt("R11", 16'd0);

        // Vector table: R2 R3 R4 R5 R6 R7 R9
        for (int v = 0; v < NV; v++) begin
            gate_i = VECS[v].gate;
            cyc(1);
            write_mode(VECS[v].mode);
            load(VECS[v].cnt);
            ticks(int'(VECS[v].ticks));
            check_out($sformatf("R%0d vec%0d", VECS[v].req, v), VECS[v].exp_out);
            check_cnt($sformatf("R%0d vec%0d", VECS[v].req, v), VECS[v].exp_cnt);
        end

        // R10 mode write sets idle level and freezes counting
        gate_i = 1'b1;
        write_mode(3'd0);
        load(16'd9);
        ticks(2);
        held = count_o;
        write_mode(3'd2);
        check_out("R10 idle mode2", 1'b1);
        ticks(3);
        check_cnt("R10 frozen", held);
        write_mode(3'd0);
        check_out("R10 idle mode0", 1'b0);

        // R12 no tick enable, count holds
        load(16'd7);
        cyc(5);
        check_cnt("R12", 16'd7);

        // R1 zero count is 65536 in mode 0
        write_mode(3'd0);
        load(16'd0);
        ticks(1);
        check_cnt("R1 first tick", 16'hFFFF);
        ticks(65534);
        check_out("R1 before tc", 1'b0);
        check_cnt("R1 before tc", 16'd1);
        ticks(1);
        check_out("R1 at tc", 1'b1);

        // R8 mode 1 retrigger
        gate_i = 1'b0;
        write_mode(3'd1);
        load(16'd5);
        ticks(5);
        check_out("R8 m1 expired", 1'b1);
        gate_i = 1'b1;
        cyc(1);
        check_cnt("R8 m1 restart", 16'd5);
        check_out("R8 m1 restart", 1'b0);

        // R8 mode 2 retrigger
        write_mode(3'd2);
        load(16'd4);
        ticks(2);
        gate_i = 1'b0;
        cyc(1);
        gate_i = 1'b1;
        cyc(1);
        check_cnt("R8 m2 restart", 16'd4);

        // R8 mode 0 gate edge does not restart
        write_mode(3'd0);
        load(16'd5);
        ticks(2);
        gate_i = 1'b0;
        cyc(1);
        gate_i = 1'b1;
        cyc(1);
        check_cnt("R8 m0 no restart", 16'd3);

        // R6 mode 5 strobe fires once, not after wrap
        write_mode(3'd5);
        load(16'd2);
        ticks(2);
        check_out("R6 m5 strobe", 1'b0);
        ticks(65536);
        check_cnt("R6 m5 wrapped", 16'd0);
        check_out("R6 m5 no repeat", 1'b1);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule